// File: doc/BRIEF.md
# ROM PCM Sample Streamer with PWM Output

This block plays a fixed audio clip held in an on-chip synchronous read-only memory. A fractional rate accumulator divides the system clock into a one-cycle sample tick. At the default settings this is 44.1 kHz from a 100 MHz clock. On every tick an address counter moves one step through the memory. The 8-bit unsigned sample that comes back is loaded into a pulse-width modulator, and the modulator's single output bit drives the audio pin.

The memory sits outside the block. The block drives the read address, and the memory returns the data one clock later. The clip length sets the last address that is played. Loop mode chooses between restarting the clip and stopping at its end. Dropping the enable input silences the output and rewinds the clip. The rate parameters must satisfy 2·RATE_HZ ≤ CLK_HZ, so that two ticks can never fall on adjacent cycles.

Top module: `pcm_pwm_player`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `mem_addr` is 0 and `pwm_out` is 0.
- R2: The sample tick comes from an accumulator that starts at 0 and adds RATE_HZ on each enabled cycle. A tick fires on a cycle where the sum reaches CLK_HZ or more, and CLK_HZ is then subtracted from the sum. The average tick rate is therefore exactly RATE_HZ per CLK_HZ cycles.
- R3: Playback starts at address 0. On each tick the address goes up by one, so it changes on the clock edge that ends the tick cycle.
- R4: When a tick leaves address A, `mem_data` is captured into the held sample on the edge one cycle after the address change. `pwm_out` reflects that sample from the following edge onwards.
- R5: An 8-bit counter runs freely from reset. `pwm_out` is registered and is high when the counter is below the held sample. Over any 256 consecutive cycles of one sample, the number of high cycles equals the sample value: 0 gives no high cycles and 255 gives 255.
- R6: A tick at address `clip_len-1` with `loop_mode` high returns the address to 0, and playback continues.
- R7: A tick at address `clip_len-1` with `loop_mode` low keeps the address at `clip_len-1`. The last sample still plays for one full tick period. From the next tick onwards the held sample is 0 and `pwm_out` stays low until enable is dropped.
- R8: While `enable` is low, the address is 0 and `pwm_out` is low from the next cycle onwards. The accumulator and the held sample are cleared. Raising `enable` again starts the clip from address 0.
- R9: A `clip_len` of 0 selects the full memory of 2^ADDR_W samples, so the last address is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Playback enable; low rewinds and silences |
| loop_mode | input | 1 | 1 = restart the clip at its end, 0 = stop |
| clip_len | input | ADDR_W | Number of samples in the clip; 0 means the full memory |
| mem_addr | output | ADDR_W | Read address to the sample memory |
| mem_data | input | SAMPLE_W | Sample returned by the memory one cycle after the address |
| pwm_out | output | 1 | Modulated audio bit |

## Verification
A cycle-level model of the tick, address and modulator rules is compared with the address and the PWM bit on every cycle. Random segments change the clip length, loop mode and enable, and each one runs long enough to reach the end of its clip. This separates a wrap from a stop, exposes an off-by-one at the last address, and shows whether the accumulator and the clip restart after a drop in enable. Directed runs count high cycles over a 256-cycle window for chosen samples, including 0 and 255, to catch errors in the compare and in the fetch latency. Further directed runs play a full-depth clip with length 0 and hold the output in the stopped state for a long time.

// File: rtl/pcm_player_pkg.sv
// Package: shared types for the PCM streamer.
// Assumes: nothing beyond the standard language.
package pcm_player_pkg;

    // Playback phase of the sample fetcher.
    typedef enum logic [1:0] {
        PB_RUN   = 2'd0,   // stepping through the clip
        PB_DRAIN = 2'd1,   // last sample fetched, still sounding
        PB_HALT  = 2'd2    // clip finished, output silent
    } pb_state_t;

endpackage

// File: rtl/rate_tick_gen.sv
// Module: rate_tick_gen
// Produces a one-cycle tick at an average of RATE_HZ ticks per CLK_HZ
// clock cycles by means of a modulo accumulator.
// Assumes: 0 < RATE_HZ and 2*RATE_HZ <= CLK_HZ, so ticks never touch.
module rate_tick_gen #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned RATE_HZ = 44_100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(RATE_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    // Next accumulator value and tick decision.
    always_comb begin
        sum  = acc_q + STEP;
        tick = run && (sum >= LIMIT);
    end

    // Accumulate, wrap on tick, clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum - LIMIT;
        end else begin
            acc_q <= sum;
        end
    end
endmodule

// File: rtl/sample_fetch.sv
// Module: sample_fetch
// Walks the read address through the clip on each tick, captures the
// memory word one cycle later and handles the end of the clip.
// Assumes: the memory returns data one cycle after the address, and
// ticks are at least two cycles apart.
module sample_fetch
    import pcm_player_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                loop_mode,
    input  logic [ADDR_W-1:0]   clip_len,
    input  logic                tick,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [SAMPLE_W-1:0] mem_data,
    output logic [SAMPLE_W-1:0] sample_q,
    output pb_state_t           state_q,
    output logic [ADDR_W-1:0]   last_idx
);
    logic [ADDR_W-1:0] addr_q;
    logic              load_q;
    logic              at_end;

    // Last address to play; a length of 0 wraps to the full depth.
    always_comb begin
        last_idx = clip_len - 1'b1;
        at_end   = (addr_q == last_idx);
        mem_addr = addr_q;
    end

    // Address counter and playback phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            addr_q  <= '0;
            state_q <= PB_RUN;
        end else if (tick) begin
            unique case (state_q)
                PB_RUN: begin
                    if (!at_end) begin
                        addr_q <= addr_q + 1'b1;
                    end else if (loop_mode) begin
                        addr_q <= '0;
                    end else begin
                        state_q <= PB_DRAIN;
                    end
                end
                PB_DRAIN: state_q <= PB_HALT;
                default:  state_q <= PB_HALT;
            endcase
        end
    end

    // Remember that a fetch was issued so the data is taken next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            load_q <= 1'b0;
        end else begin
            load_q <= tick && (state_q == PB_RUN);
        end
    end

    // Held sample: load fetched data, clear when the clip has drained.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sample_q <= '0;
        end else if (tick && state_q == PB_DRAIN) begin
            sample_q <= '0;
        end else if (load_q) begin
            sample_q <= mem_data;
        end
    end
endmodule

// File: rtl/pwm_mod.sv
// Module: pwm_mod
// Compares a free-running counter with the held sample and registers
// the result as the modulated output bit.
// Assumes: the sample is unsigned; full scale is 2**SAMPLE_W - 1.
module pwm_mod #(
    parameter int unsigned SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SAMPLE_W-1:0] level,
    output logic                pwm_q
);
    logic [SAMPLE_W-1:0] cnt_q;

    // Free-running carrier counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered compare, forced low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= run && (cnt_q < level);
        end
    end
endmodule

// File: rtl/pcm_pwm_player.sv
// Module: pcm_pwm_player
// Top level: rate tick, clip addressing and PWM output of a stored clip.
// Assumes: an external synchronous memory with one cycle of read latency,
// and 2*RATE_HZ <= CLK_HZ.
module pcm_pwm_player
    import pcm_player_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned RATE_HZ  = 44_100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                loop_mode,
    input  logic [ADDR_W-1:0]   clip_len,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [SAMPLE_W-1:0] mem_data,
    output logic                pwm_out
);
    logic                tick;
    logic [SAMPLE_W-1:0] sample_q;
    pb_state_t           state_q;
    logic [ADDR_W-1:0]   last_idx;

    rate_tick_gen #(
        .CLK_HZ  (CLK_HZ),
        .RATE_HZ (RATE_HZ)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .tick  (tick)
    );

    sample_fetch #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .loop_mode (loop_mode),
        .clip_len  (clip_len),
        .tick      (tick),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .sample_q  (sample_q),
        .state_q   (state_q),
        .last_idx  (last_idx)
    );

    pwm_mod #(
        .SAMPLE_W (SAMPLE_W)
    ) i_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .level (sample_q),
        .pwm_q (pwm_out)
    );
endmodule

// File: rtl/pcm_player_checker.sv
// Module: pcm_player_checker
// Temporal properties of the streamer, attached to the top by bind.
// Assumes: 2*RATE_HZ <= CLK_HZ.
module pcm_player_checker
    import pcm_player_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                loop_mode,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                pwm_out,
    input logic                tick,
    input logic [SAMPLE_W-1:0] sample_q,
    input pb_state_t           state_q,
    input logic [ADDR_W-1:0]   last_idx
);
    // Ticks never fall on adjacent cycles (R2).
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // Address only moves on a tick, by one or back to zero (R3).
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> (mem_addr == $past(mem_addr)));

    // Zero sample yields a low output on the next edge (R5).
    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q == '0) |=> !pwm_out);

    // Looping end wraps the address to zero (R6).
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == PB_RUN && mem_addr == last_idx && loop_mode)
        |=> (mem_addr == '0 || !enable));

    // Halted playback is silent (R7).
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PB_HALT) |=> !pwm_out);

    // Disabled block rewinds and goes silent (R8).
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (mem_addr == '0 && !pwm_out));
endmodule

bind pcm_pwm_player pcm_player_checker #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .loop_mode (loop_mode),
    .mem_addr  (mem_addr),
    .pwm_out   (pwm_out),
    .tick      (tick),
    .sample_q  (sample_q),
    .state_q   (state_q),
    .last_idx  (last_idx)
);

// File: tb/test_pcm_pwm_player.sv
module test_pcm_pwm_player;
    localparam int AW   = 6;
    localparam int SW   = 8;
    localparam int CHZ  = 1000;
    localparam int RHZ  = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          loop_mode = 1'b0;
    logic [AW-1:0] clip_len = '0;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_data = '0;
    logic          pwm_out;

    logic [SW-1:0] rom [DEPTH];
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    pcm_pwm_player #(
        .ADDR_W(AW), .SAMPLE_W(SW), .CLK_HZ(CHZ), .RATE_HZ(RHZ)
    ) i_pcm_pwm_player (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loop_mode(loop_mode),
        .clip_len(clip_len), .mem_addr(mem_addr), .mem_data(mem_data),
        .pwm_out(pwm_out)
    );

    // synchronous memory model
    always @(posedge clk) mem_data <= rom[mem_addr];

    // requirement-level reference model
    int          m_acc;
    int          m_addr;
    int          m_st;      // 0 run, 1 drain, 2 halt
    int          m_samp;
    bit          m_pend;
    int          m_paddr;
    int          m_cnt;
    bit          m_pwm;

    function automatic int last_of(input logic [AW-1:0] len);
        return (len == 0) ? DEPTH - 1 : int'(len) - 1;   // R9
    endfunction

    always @(posedge clk) begin
        bit tk;
        bit npwm;
        if (!rst_n) begin
            m_acc = 0; m_addr = 0; m_st = 0; m_samp = 0; m_pend = 0;
            m_paddr = 0; m_cnt = 0; m_pwm = 0;
        end else begin
            npwm = enable && (m_cnt < m_samp);
            m_cnt = (m_cnt + 1) % 256;
            if (!enable) begin
                m_acc = 0; m_addr = 0; m_st = 0; m_samp = 0; m_pend = 0;
            end else begin
                tk = (m_acc + RHZ >= CHZ);
                m_acc = tk ? m_acc + RHZ - CHZ : m_acc + RHZ;
                if (tk && m_st == 1) begin
                    m_samp = 0; m_st = 2;
                end else if (m_pend) begin
                    m_samp = rom[m_paddr];
                end
                m_pend = 0;
                if (tk && m_st == 0) begin
                    m_pend = 1; m_paddr = m_addr;
                    if (m_addr == last_of(clip_len)) begin
                        if (loop_mode) m_addr = 0; else m_st = 1;
                    end else begin
                        m_addr = m_addr + 1;
                    end
                end
            end
            m_pwm = npwm;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(mem_addr) != m_addr) begin
                failures++;
                $display("FAIL R2/R3 addr cyc=%0d actual=%0d expected=%0d", cyc, mem_addr, m_addr);
            end
            checks++;
            if (pwm_out !== m_pwm) begin
                failures++;
                $display("FAIL R4/R5 pwm cyc=%0d actual=%0b expected=%0b", cyc, pwm_out, m_pwm);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for the address to leave a value, then count one PWM window
    task automatic duty_window(input string req, output int played, output int highs);
        int a0;
        a0 = int'(mem_addr);
        while (int'(mem_addr) == a0) @(negedge clk);
        played = a0;
        wait_cyc(2);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int played;
        int highs;
        void'($urandom(32'h5A17));
        for (int i = 0; i < DEPTH; i++) rom[i] = SW'($urandom);
        rom[0] = 8'd128; rom[1] = 8'd0; rom[2] = 8'd255; rom[3] = 8'd1;

        wait_cyc(4);
        check("R1 addr in reset", int'(mem_addr), 0);
        check("R1 pwm in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 addr after reset", int'(mem_addr), 0);
        check("R1 pwm after reset", int'(pwm_out), 0);

        // directed: duty of samples 128, 0, 255, 1
        clip_len = 6'd8; loop_mode = 1'b0; enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            duty_window("R5", played, highs);
            check("R4/R5 duty", highs, rom[played]);
        end

        // directed: stop at end (R7)
        clip_len = 6'd3; enable = 1'b0; wait_cyc(3);
        check("R8 addr while disabled", int'(mem_addr), 0);
        check("R8 pwm while disabled", int'(pwm_out), 0);
        enable = 1'b1;
        wait_cyc(4 * 340);
        check("R7 addr holds last", int'(mem_addr), 2);
        highs = 0;
        for (int i = 0; i < 600; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
        check("R7 silent after drain", highs, 0);

        // directed: loop wrap (R6)
        enable = 1'b0; wait_cyc(2);
        clip_len = 6'd2; loop_mode = 1'b1; enable = 1'b1;
        wait_cyc(2 * 340 + 10);
        check("R6 wrapped to zero", int'(mem_addr), 0);

        // directed: full depth with length 0 (R9)
        enable = 1'b0; wait_cyc(2);
        clip_len = '0; loop_mode = 1'b1; enable = 1'b1;
        while (int'(mem_addr) != DEPTH - 1) @(negedge clk);
        check("R9 reaches top address", int'(mem_addr), DEPTH - 1);
        while (int'(mem_addr) == DEPTH - 1) @(negedge clk);
        check("R9 wraps after full depth", int'(mem_addr), 0);

        // random segments against the model
        for (int s = 0; s < 24; s++) begin
            if ($urandom_range(0, 3) == 0) begin
                enable = 1'b0;
                wait_cyc($urandom_range(1, 5));
                check("R8 rewound", int'(mem_addr), 0);
            end
            clip_len  = AW'($urandom_range(0, 7));
            loop_mode = 1'($urandom_range(0, 1));
            enable    = 1'b1;
            wait_cyc($urandom_range(800, 3000));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule